// File: doc/BRIEF.md
# DVMA Address Translation Unit

This block sits between an I/O bus and main memory and turns device virtual addresses into physical addresses for DMA. A bus master presents an address, a slot number and a read/write flag on a request port. The block answers one cycle later on a hit, or after a single page-table fetch on a miss, with a physical address, a cacheable flag and a fault flag.

The page table is a flat array of 32-bit entries in memory. Its base address is programmed through a small register port. The translated window is a power-of-two region that always ends at the top of the 32-bit address space. Recent translations are kept in a small fully associative cache. Software keeps that cache coherent through two write-only words: one drops every entry, the other drops the entry for a single page.

Each bus slot can be configured to skip translation entirely. Its addresses are then treated as physical, with bit 30 supplied from the slot's configuration word.

Top module: `dvma_xlate`

## Requirements
- R1: After reset the control word reads back as the implementation code in bits 31:28 and the version code in bits 27:24, with every other bit zero. `req_ready` is high, `rsp_valid` is low and `tbl_rd` is low.
- R2: Register word addresses on `reg_addr` are: 0 control, 1 table base, 2 flush-all, 3 flush-page, 4 to 7 slot configuration for slots 0 to 3.
  - In the control word, only bit 0 (enable) and bits 4:2 (range) are writable.
  - The table base reads back with bits 1:0 forced to zero.
  - A slot word keeps only bits 16 and 0.
  - The flush words read as zero.
- R3: Range value r selects a window of 2^(24+r) bytes ending at 0xFFFFFFFF. So r=0 starts at 0xFF000000, r=1 at 0xFE000000 and r=7 at 0x80000000. With translation on, an address below the window start returns a fault and issues no table read.
- R4: On a miss the block reads one entry, at table base + 4 × ((address − window start) >> 12).
- R5: A page-table entry carries physical page bits PA[30:12] in entry bits 26:8, a cacheable flag in bit 7, a writable flag in bit 2 and a valid flag in bit 1. A good translation returns {0, entry[26:8], address[11:0]}, with `rsp_cacheable` equal to entry bit 7.
- R6: An entry whose valid bit is 0, or a write to an entry whose writable bit is 0, returns `rsp_fault`=1 with `rsp_paddr`=0 and `rsp_cacheable`=0.
- R7: A request whose page is held in the cache completes with no table read. The cache holds NENT pages and replaces them in round-robin order of fill.
- R8: Any write to the flush-all word, whatever the data, invalidates every cached page.
- R9: A write to the flush-page word invalidates only the cached page equal to bits 31:12 of the written data. Other pages stay cached.
- R10: A request from a slot whose configuration bit 0 is set returns {0, slot bit 16, address[29:0]} with no fault and no table read. This holds whatever the enable bit and window are.
- R11: With control bit 0 clear, a request from a non-bypass slot returns the address unchanged with no fault and no table read.
- R12: `req_ready` is high only while the block is idle. `rsp_valid` is a one-cycle pulse. Each miss produces exactly one one-cycle `tbl_rd` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Device virtual address |
| req_write | input | 1 | Request is a write |
| req_slot | input | SLOT_W | Requesting bus slot |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Translation fault |
| rsp_paddr | output | 32 | Physical address |
| rsp_cacheable | output | 1 | Page marked cacheable |
| tbl_rd | output | 1 | Page-table read request pulse |
| tbl_addr | output | 32 | Page-table entry address |
| tbl_rvalid | input | 1 | Page-table read data valid |
| tbl_rdata | input | 32 | Page-table entry |

## Verification
The bench works through the window boundary on both sides, at the smallest and largest range and one in between.
- A wrong window mask would either fetch entries for addresses outside the window or fault inside it.
- A wrong index would fetch the wrong entry, and so return the wrong physical page.

It fills the cache past its capacity so that the round-robin victim is evicted and must be fetched again. It also flushes a single page and checks that a neighbour still hits, which catches a page flush that behaves like a flush-all. Bypass slots are tested with both values of the bit-30 source and with a write request, so that a bypass wrongly routed through the table would show up as a fault or as an extra table read.

// File: rtl/dvma_xlate.sv
module dvma_xlate #(
  parameter int NENT = 4,
  parameter int SLOT_W = 2,
  parameter logic [3:0] IMPL = 4'h3,
  parameter logic [3:0] VER = 4'h2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_vaddr,
  input  logic              req_write,
  input  logic [SLOT_W-1:0] req_slot,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [31:0]       rsp_paddr,
  output logic              rsp_cacheable,
  output logic              tbl_rd,
  output logic [31:0]       tbl_addr,
  input  logic              tbl_rvalid,
  input  logic [31:0]       tbl_rdata
);
  localparam int NSLOT = 1 << SLOT_W;
  localparam int EW = (NENT > 1) ? $clog2(NENT) : 1;

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_WAIT} st_t;

  st_t               st;
  logic              en;
  logic [2:0]        rng;
  logic [31:0]       base;
  logic [NSLOT-1:0]  byp, sab;
  logic [31:0]       va;
  logic              wr;
  logic [SLOT_W-1:0] slot;
  logic              kill;

  logic [NENT-1:0]   ev;
  logic [19:0]       evpn [NENT];
  logic [31:0]       epte [NENT];
  logic [EW-1:0]     vic;

  wire wr_fa = reg_wr && reg_addr == 3'd2;
  wire wr_fp = reg_wr && reg_addr == 3'd3;

  wire [7:0]  lowm   = ~(8'hFF << rng);
  wire        in_win = &(va[31:24] | lowm);
  wire [19:0] idx    = {va[31:24] & lowm, va[23:12]};

  logic [NENT-1:0] hitv;
  logic [31:0]     hpte;
  wire             hit = |hitv;

  for (genvar i = 0; i < NENT; i++) begin : g_cmp
    assign hitv[i] = ev[i] && evpn[i] == va[31:12];
  end

  always_comb begin
    hpte = '0;
    for (int i = 0; i < NENT; i++)
      if (hitv[i]) hpte = hpte | epte[i];
  end

  function automatic logic [33:0] resolve(input logic [31:0] p, input logic w, input logic [11:0] off);
    if (!p[1] || (w && !p[2])) return {1'b1, 1'b0, 32'h0};
    return {1'b0, p[7], 1'b0, p[26:8], off};
  endfunction

  assign req_ready = st == S_IDLE;

  always_comb begin
    unique case (reg_addr)
      3'd0:    reg_rdata = {IMPL, VER, 19'h0, rng, 1'b0, en};
      3'd1:    reg_rdata = base;
      3'd2,
      3'd3:    reg_rdata = '0;
      default: reg_rdata = {15'h0, sab[reg_addr[SLOT_W-1:0]], 15'h0, byp[reg_addr[SLOT_W-1:0]]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0;
      rng <= '0;
      base <= '0;
      byp <= '0;
      sab <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        3'd0: begin
          en  <= reg_wdata[0];
          rng <= reg_wdata[4:2];
        end
        3'd1: base <= {reg_wdata[31:2], 2'b00};
        3'd4, 3'd5, 3'd6, 3'd7: begin
          byp[reg_addr[SLOT_W-1:0]] <= reg_wdata[0];
          sab[reg_addr[SLOT_W-1:0]] <= reg_wdata[16];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      va <= '0;
      wr <= 1'b0;
      slot <= '0;
      kill <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      rsp_cacheable <= 1'b0;
      tbl_rd <= 1'b0;
      tbl_addr <= '0;
    end else begin
      rsp_valid <= 1'b0;
      tbl_rd <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          va <= req_vaddr;
          wr <= req_write;
          slot <= req_slot;
          kill <= 1'b0;
          st <= S_LOOK;
        end
        S_LOOK: begin
          st <= S_IDLE;
          if (byp[slot] || !en || !in_win || hit) begin
            rsp_valid <= 1'b1;
          end
          if (byp[slot]) begin
            {rsp_fault, rsp_cacheable} <= 2'b00;
            rsp_paddr <= {1'b0, sab[slot], va[29:0]};
          end else if (!en) begin
            {rsp_fault, rsp_cacheable} <= 2'b00;
            rsp_paddr <= va;
          end else if (!in_win) begin
            {rsp_fault, rsp_cacheable} <= 2'b10;
            rsp_paddr <= '0;
          end else if (hit) begin
            {rsp_fault, rsp_cacheable, rsp_paddr} <= resolve(hpte, wr, va[11:0]);
          end else begin
            tbl_rd <= 1'b1;
            tbl_addr <= base + {10'h0, idx, 2'b00};
            st <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (wr_fa || wr_fp) kill <= 1'b1;
          if (tbl_rvalid) begin
            rsp_valid <= 1'b1;
            {rsp_fault, rsp_cacheable, rsp_paddr} <= resolve(tbl_rdata, wr, va[11:0]);
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  wire fill = st == S_WAIT && tbl_rvalid && !kill && !wr_fa && !wr_fp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev <= '0;
      vic <= '0;
    end else begin
      if (fill) begin
        ev[vic] <= 1'b1;
        vic <= (vic == EW'(NENT - 1)) ? '0 : vic + 1'b1;
      end
      for (int i = 0; i < NENT; i++)
        if (wr_fa || (wr_fp && evpn[i] == reg_wdata[31:12])) ev[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      evpn[vic] <= va[31:12];
      epte[vic] <= tbl_rdata;
    end
  end
endmodule

module dvma_xlate_chk #(
  parameter int SLOT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [31:0]       req_vaddr,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic [31:0]       rsp_paddr,
  input logic              rsp_cacheable,
  input logic              tbl_rd,
  input logic [31:0]       tbl_addr
);
  logic [11:0] off_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) off_q <= '0;
    else if (req_valid && req_ready) off_q <= req_vaddr[11:0];

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R12
  AST_TBL_PULSE: assert property (@(posedge clk) disable iff (!rst_n) tbl_rd |=> !tbl_rd); // R12
  AST_BUSY_ON_FETCH: assert property (@(posedge clk) disable iff (!rst_n) tbl_rd |-> !req_ready); // R12
  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_fault) |-> (rsp_paddr == 32'h0 && !rsp_cacheable)); // R6
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_fault) |-> rsp_paddr[11:0] == off_q); // R5
  AST_TBL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) tbl_rd |-> tbl_addr[1:0] == 2'b00); // R4
endmodule

bind dvma_xlate dvma_xlate_chk #(.SLOT_W(SLOT_W)) u_chk (.*);

// File: tb/dvma_xlate_test.sv
`timescale 1ns/1ps
module dvma_xlate_test;
  localparam logic [31:0] BASE = 32'h0010_0000;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic req_valid = 0, req_ready, req_write = 0;
  logic [31:0] req_vaddr = 0;
  logic [1:0] req_slot = 0;
  logic rsp_valid, rsp_fault, rsp_cacheable;
  logic [31:0] rsp_paddr;
  logic tbl_rd, tbl_rvalid = 0;
  logic [31:0] tbl_addr, tbl_rdata = 0;

  int checks = 0, fails = 0, reads = 0;
  logic [31:0] last_ta = 0;
  logic g_f, g_c;
  logic [31:0] g_p;
  int g_miss;
  logic b_en = 0;
  logic [2:0] b_rng = 0;
  logic [3:0] b_byp = 0, b_sab = 0;

  always #10 clk = ~clk;

  dvma_xlate uut (.*);

  function automatic logic [31:0] memf(input logic [31:0] a);
    logic [19:0] i;
    i = 20'((a - BASE) >> 2);
    return {5'h0, i[18:0] ^ 19'h2A5C3, i[2], 4'h0, ~i[0], i[1:0] != 2'd3, 1'b0};
  endfunction

  function automatic logic [33:0] model(input logic [1:0] s, input logic [31:0] v, input logic w);
    logic [31:0] start, p;
    if (b_byp[s]) return {2'b00, 1'b0, b_sab[s], v[29:0]};
    if (!b_en) return {2'b00, v};
    start = ~((32'd1 << (24 + b_rng)) - 32'd1);
    if (v < start) return {2'b10, 32'h0};
    p = memf(BASE + (((v - start) >> 12) << 2));
    if (!p[1] || (w && !p[2])) return {2'b10, 32'h0};
    return {1'b0, p[7], 1'b0, p[26:8], v[11:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic run(input logic [1:0] s, input logic [31:0] v, input logic w);
    int r0, n;
    bit got;
    r0 = reads; got = 0;
    @(negedge clk);
    req_valid = 1; req_slot = s; req_vaddr = v; req_write = w;
    @(negedge clk);
    req_valid = 0;
    for (n = 0; n < 20 && !got; n++) begin
      if (rsp_valid) begin
        got = 1; g_f = rsp_fault; g_p = rsp_paddr; g_c = rsp_cacheable;
      end else @(negedge clk);
    end
    chk(got, "R12 response", 32'(got), 32'd1);
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R12 pulse", {rsp_valid, req_ready}, 32'd1);
    g_miss = reads - r0;
  endtask

  task automatic vec(input logic [1:0] s, input logic [31:0] v, input logic w, input int miss, input string tag);
    logic [33:0] e;
    e = model(s, v, w);
    run(s, v, w);
    chk(g_f == e[33], {tag, " fault"}, 32'(g_f), 32'(e[33]));
    chk(g_p == e[31:0], {tag, " paddr"}, g_p, e[31:0]);
    chk(g_c == e[32], {tag, " cacheable"}, 32'(g_c), 32'(e[32]));
    chk(g_miss == miss, {tag, " table reads"}, 32'(g_miss), 32'(miss));
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (tbl_rd) begin
        last_ta = tbl_addr; reads++;
        @(negedge clk); @(negedge clk);
        tbl_rdata = memf(last_ta); tbl_rvalid = 1;
        @(negedge clk);
        tbl_rvalid = 0;
      end
    end
  end

  localparam int NV = 11;
  // {slot, write, expected table reads, vaddr}
  localparam logic [35:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b1, 32'hFF000123},
    {2'd0, 1'b0, 1'b0, 32'hFF000FFF},
    {2'd0, 1'b1, 1'b1, 32'hFF001010},
    {2'd0, 1'b0, 1'b0, 32'hFF001010},
    {2'd0, 1'b0, 1'b1, 32'hFF003000},
    {2'd0, 1'b0, 1'b0, 32'hFEFFFFFF},
    {2'd2, 1'b1, 1'b0, 32'h12345678},
    {2'd3, 1'b0, 1'b0, 32'hFFFFF004},
    {2'd1, 1'b0, 1'b1, 32'hFFFFE004},
    {2'd0, 1'b0, 1'b1, 32'hFF002000},
    {2'd0, 1'b0, 1'b1, 32'hFF000004}
  };
  localparam string TAGS [NV] = '{"R5", "R7", "R6", "R7", "R6", "R3", "R10", "R10", "R5", "R4", "R7"};

  initial begin
    #(20 * 200000);
    fails++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !tbl_rd, "R1 outputs", {req_ready, rsp_valid, tbl_rd}, 32'h4);
    rst_n = 1;
    rreg(3'd0, d);
    chk(d == 32'h3200_0000, "R1 control", d, 32'h3200_0000);

    wreg(3'd0, 32'hFFFF_FFFF);
    rreg(3'd0, d);
    chk(d == 32'h3200_001D, "R2 control", d, 32'h3200_001D);
    wreg(3'd1, BASE | 32'h3);
    rreg(3'd1, d);
    chk(d == BASE, "R2 base", d, BASE);
    wreg(3'd6, 32'hFFFF_FFFF);
    rreg(3'd6, d);
    chk(d == 32'h0001_0001, "R2 slot", d, 32'h0001_0001);
    rreg(3'd2, d);
    chk(d == 32'h0, "R2 flush word", d, 32'h0);
    wreg(3'd7, 32'h0000_0001);
    wreg(3'd0, 32'h1);
    b_en = 1; b_rng = 0; b_byp = 4'b1100; b_sab = 4'b0100;

    for (int i = 0; i < NV; i++)
      vec(VEC[i][35:34], VEC[i][31:0], VEC[i][33], int'(VEC[i][32]), TAGS[i]);

    wreg(3'd3, 32'hFF00_2ABC);
    vec(2'd0, 32'hFF002000, 1'b0, 1, "R9 flushed page");
    chk(last_ta == BASE + 32'h8, "R4 entry address", last_ta, BASE + 32'h8);
    vec(2'd0, 32'hFF000FF0, 1'b0, 0, "R9 neighbour kept");
    wreg(3'd2, 32'h0);
    vec(2'd0, 32'hFF000FF0, 1'b0, 1, "R8 flush all");
    vec(2'd1, 32'hFF002004, 1'b0, 1, "R8 second page refetched");

    wreg(3'd0, 32'h1D);
    b_rng = 7;
    vec(2'd0, 32'h80000000, 1'b1, 1, "R3 2GB start");
    chk(last_ta == BASE, "R4 2GB index", last_ta, BASE);
    vec(2'd0, 32'h7FFFFFFF, 1'b0, 0, "R3 2GB below");
    wreg(3'd0, 32'h5);
    b_rng = 1;
    vec(2'd0, 32'hFE000010, 1'b0, 1, "R3 32MB start");
    chk(last_ta == BASE, "R4 32MB index", last_ta, BASE);
    vec(2'd0, 32'hFDFFF000, 1'b0, 0, "R3 32MB below");

    wreg(3'd0, 32'h0);
    b_en = 0;
    vec(2'd0, 32'hFF000123, 1'b1, 0, "R11 disabled");
    vec(2'd2, 32'h0ABCDEF0, 1'b0, 0, "R10 bypass while disabled");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule